// File: doc/BRIEF.md
# Dual-Line PDM Microphone Front End

This block is the capture front end for up to four pulse-density-modulated microphones that share two one-bit data wires. It always drives the microphone bit clock itself, making it from the core clock by a fixed even division, and on each data wire two microphones take turns: one drives the wire while the bit clock is high, the other while it is low. The block brings each wire into the core clock domain, takes one sample at the end of each clock phase, and routes the samples to output channels.

Every channel has its own routing: a line select picks the data wire and a slot select picks the high or the low phase. Per-channel enables gate the output bits. Clearing every enable stops the bit clock and capture; setting the enables again restarts them from the start of a clock period. Once per bit-clock period all channel bits are presented together with a one-cycle valid strobe. The routing can only be reloaded while capture is stopped, and a routing that gives two channels the same wire and phase is refused. Filtering, decimation and buffering are left to the logic downstream.

Top module: `pdm_mic_front`

## Requirements
- R1: While any bit of `chan_en` is set, `pdm_clk` is a square wave with a period of CLK_DIV core cycles (16 by default), high for the first CLK_DIV/2 cycles; it goes high in the first cycle after the enables turn from all-zero to non-zero.
- R2: While `chan_en` is all zero, `pdm_clk` and `pcm_valid` are low from the next cycle on and stay low.
- R3: A channel whose slot bit is 0 receives the level its selected wire held late in the high phase of the period; a slot bit of 1 selects the level held late in the low phase. Wire levels pass through two synchronizing flops, so a level must be held from the middle of a phase to its end.
- R4: The line bit of channel c (bit c of `cfg_line`) selects data wire 0 or 1 (`pdm_line[0]` or `pdm_line[1]`).
- R5: `pcm_valid` is high for exactly one core cycle per bit-clock period, in the cycle in which `pdm_clk` goes high again, and `pcm_bits` changes only in that cycle.
- R6: A channel whose enable bit is 0 at the end of the period outputs 0 in `pcm_bits`.
- R7: A `cfg_load` pulse copies `cfg_slot` and `cfg_line` into the routing only when `chan_en` is all zero and the bit clock has stopped; a pulse at any other time leaves the routing unchanged.
- R8: A `cfg_load` whose routing gives two channels the same (wire, slot) pair is ignored.
- R9: After reset `pdm_clk`, `pcm_valid` and `pcm_bits` are 0, and the routing is channel 0 = wire 0 high, channel 1 = wire 0 low, channel 2 = wire 1 high, channel 3 = wire 1 low (slot bits 4'b1010, line bits 4'b1100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, CLK_DIV times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | N_CH | Per-channel capture enable; all zero stops the bit clock |
| cfg_load | input | 1 | Pulse to load the routing from `cfg_slot` and `cfg_line` |
| cfg_slot | input | N_CH | Per-channel phase select: 0 high phase, 1 low phase |
| cfg_line | input | N_CH*LW | Per-channel data wire index, LW bits per channel |
| pdm_line | input | N_LINE | Asynchronous microphone data wires |
| pdm_clk | output | 1 | Bit clock driven to the microphones |
| pcm_bits | output | N_CH | One PDM bit per channel, aligned across channels |
| pcm_valid | output | 1 | One-cycle strobe marking new `pcm_bits` |

## Verification
A vector table sets different level pairs on the two wires in the high and low phases, such as 01/10 against 10/01, so a swapped wire or swapped phase in the routing produces a distinct wrong bit pattern; partial enable masks show disabled channels forced to zero. The routing is then reloaded to a different permutation, once while enabled, once with a duplicate pair and once legally, and each time the same data pattern is replayed so the output reveals which routing is in force. Directed tests measure the high and low phase lengths, count valid strobes over a fixed window, hold the enables at zero to confirm a silent clock, and time the first rising edge after restart.

// File: rtl/pdm_front_pkg.sv
package pdm_front_pkg;

    localparam int DEF_N_CH    = 4;
    localparam int DEF_N_LINE  = 2;
    localparam int DEF_CLK_DIV = 16;

    typedef enum logic {
        SLOT_HIGH = 1'b0,
        SLOT_LOW  = 1'b1
    } slot_e;

    typedef struct packed {
        logic hi_end;
        logic lo_end;
    } phase_strobe_t;

    function automatic int line_idx_width(input int n_line);
        return (n_line > 1) ? $clog2(n_line) : 1;
    endfunction

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
    import pdm_front_pkg::*;
#(
    parameter int CLK_DIV = DEF_CLK_DIV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic          bit_clk,
    output phase_strobe_t stb
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = $clog2(CLK_DIV);

    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             active, active_nx;

    always_comb begin
        if (!run) begin
            active_nx = 1'b0;
            cnt_nx    = '0;
        end else if (!active) begin
            active_nx = 1'b1;
            cnt_nx    = '0;
        end else begin
            active_nx = 1'b1;
            cnt_nx    = (cnt == CNT_W'(CLK_DIV - 1)) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cnt     <= '0;
            bit_clk <= 1'b0;
        end else begin
            active  <= active_nx;
            cnt     <= cnt_nx;
            bit_clk <= active_nx && (cnt_nx < CNT_W'(HALF));
        end
    end

    assign stb.hi_end = run && active && (cnt == CNT_W'(HALF - 1));
    assign stb.lo_end = run && active && (cnt == CNT_W'(CLK_DIV - 1));

endmodule

// File: rtl/pdm_line_sync.sv
module pdm_line_sync #(
    parameter int N_LINE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_LINE-1:0] line_in,
    output logic [N_LINE-1:0] line_out
);
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= line_in[l];
                stage2 <= stage1;
            end
        end
        assign line_out[l] = stage2;
    end

endmodule

// File: rtl/pdm_route_cfg.sv
module pdm_route_cfg #(
    parameter int N_CH = 4,
    parameter int LW   = 1,
    parameter logic [N_CH-1:0]    RST_SLOT = 4'b1010,
    parameter logic [N_CH*LW-1:0] RST_LINE = 4'b1100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle,
    input  logic                 load,
    input  logic [N_CH-1:0]      slot_in,
    input  logic [N_CH*LW-1:0]   line_in,
    output logic [N_CH-1:0]      slot_map,
    output logic [N_CH*LW-1:0]   line_map
);
    logic clash;

    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            for (int j = i + 1; j < N_CH; j++) begin
                if ((line_in[i*LW +: LW] == line_in[j*LW +: LW]) &&
                    (slot_in[i] == slot_in[j]))
                    clash = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_map <= RST_SLOT;
            line_map <= RST_LINE;
        end else if (load && idle && !clash) begin
            slot_map <= slot_in;
            line_map <= line_in;
        end
    end

endmodule

// File: rtl/pdm_slot_capture.sv
module pdm_slot_capture
    import pdm_front_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int N_LINE = 2,
    parameter int LW     = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  phase_strobe_t        stb,
    input  logic [N_LINE-1:0]    line_s,
    input  logic [N_CH-1:0]      en,
    input  logic [N_CH-1:0]      slot_map,
    input  logic [N_CH*LW-1:0]   line_map,
    output logic [N_CH-1:0]      bits,
    output logic                 valid
);
    logic [N_LINE-1:0] hi_q;
    logic [N_CH-1:0]   pick;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [LW-1:0] idx;
        assign idx     = line_map[c*LW +: LW];
        assign pick[c] = en[c] & ((slot_e'(slot_map[c]) == SLOT_LOW) ? line_s[idx] : hi_q[idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            bits  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= stb.lo_end;
            if (stb.hi_end)
                hi_q <= line_s;
            if (stb.lo_end)
                bits <= pick;
        end
    end

endmodule

// File: rtl/pdm_mic_front.sv
module pdm_mic_front
    import pdm_front_pkg::*;
#(
    parameter int N_CH    = DEF_N_CH,
    parameter int N_LINE  = DEF_N_LINE,
    parameter int CLK_DIV = DEF_CLK_DIV,
    parameter int LW      = line_idx_width(N_LINE),
    parameter logic [N_CH-1:0]    RST_SLOT = 4'b1010,
    parameter logic [N_CH*LW-1:0] RST_LINE = 4'b1100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CH-1:0]    chan_en,
    input  logic               cfg_load,
    input  logic [N_CH-1:0]    cfg_slot,
    input  logic [N_CH*LW-1:0] cfg_line,
    input  logic [N_LINE-1:0]  pdm_line,
    output logic               pdm_clk,
    output logic [N_CH-1:0]    pcm_bits,
    output logic               pcm_valid
);
    logic               run;
    logic               idle;
    phase_strobe_t      stb;
    logic [N_LINE-1:0]  line_s;
    logic [N_CH-1:0]    slot_map;
    logic [N_CH*LW-1:0] line_map;

    assign run  = |chan_en;
    assign idle = !run && !pdm_clk && !stb.hi_end && !stb.lo_end;

    pdm_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .bit_clk (pdm_clk),
        .stb     (stb)
    );

    pdm_line_sync #(.N_LINE(N_LINE)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (pdm_line),
        .line_out (line_s)
    );

    pdm_route_cfg #(
        .N_CH     (N_CH),
        .LW       (LW),
        .RST_SLOT (RST_SLOT),
        .RST_LINE (RST_LINE)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .idle     (idle),
        .load     (cfg_load),
        .slot_in  (cfg_slot),
        .line_in  (cfg_line),
        .slot_map (slot_map),
        .line_map (line_map)
    );

    pdm_slot_capture #(
        .N_CH   (N_CH),
        .N_LINE (N_LINE),
        .LW     (LW)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .line_s   (line_s),
        .en       (chan_en),
        .slot_map (slot_map),
        .line_map (line_map),
        .bits     (pcm_bits),
        .valid    (pcm_valid)
    );

endmodule

// File: rtl/pdm_front_chk.sv
module pdm_front_chk #(
    parameter int N_CH = 4,
    parameter int LW   = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [N_CH-1:0]    chan_en,
    input logic               pdm_clk,
    input logic [N_CH-1:0]    pcm_bits,
    input logic               pcm_valid,
    input logic [N_CH-1:0]    slot_map,
    input logic [N_CH*LW-1:0] line_map
);
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (chan_en == '0) |=> (!pdm_clk && !pcm_valid)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid); // R5

    AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (pdm_clk && !$past(pdm_clk))); // R5

    AST_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> $stable(pcm_bits)); // R5

    AST_OFF_CHANNEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> ((pcm_bits & ~$past(chan_en)) == '0)); // R6

    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (chan_en != '0) |=> ($stable(slot_map) && $stable(line_map))); // R7

endmodule

bind pdm_mic_front pdm_front_chk #(.N_CH(N_CH), .LW(LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_en   (chan_en),
    .pdm_clk   (pdm_clk),
    .pcm_bits  (pcm_bits),
    .pcm_valid (pcm_valid),
    .slot_map  (slot_map),
    .line_map  (line_map)
);

// File: tb/sim_pdm_mic_front.sv
module sim_pdm_mic_front;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] chan_en  = '0;
    logic       cfg_load = 1'b0;
    logic [3:0] cfg_slot = '0;
    logic [3:0] cfg_line = '0;
    logic [1:0] pdm_line = '0;
    logic       pdm_clk;
    logic [3:0] pcm_bits;
    logic       pcm_valid;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [3:0] m_slot = 4'b1010;
    logic [3:0] m_line = 4'b1100;

    // entries: {enable[3:0], high-phase wires[1:0], low-phase wires[1:0]}
    localparam logic [7:0] VEC [0:7] = '{
        {4'hF, 2'b01, 2'b10}, {4'hF, 2'b10, 2'b01},
        {4'hF, 2'b11, 2'b00}, {4'hF, 2'b00, 2'b11},
        {4'h5, 2'b11, 2'b11}, {4'hA, 2'b11, 2'b11},
        {4'h9, 2'b10, 2'b11}, {4'h6, 2'b01, 2'b01}
    };

    pdm_mic_front u0 (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .cfg_load  (cfg_load),
        .cfg_slot  (cfg_slot),
        .cfg_line  (cfg_line),
        .pdm_line  (pdm_line),
        .pdm_clk   (pdm_clk),
        .pcm_bits  (pcm_bits),
        .pcm_valid (pcm_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [3:0] en, input logic [1:0] hi,
                                         input logic [1:0] lo);
        logic [3:0] r;
        for (int c = 0; c < 4; c++)
            r[c] = en[c] & (m_slot[c] ? lo[m_line[c]] : hi[m_line[c]]);
        return r;
    endfunction

    task automatic period(input string req, input logic [3:0] en,
                          input logic [1:0] hi, input logic [1:0] lo, input logic [3:0] exp);
        chan_en = en;
        @(negedge clk);
        while (!pdm_clk) @(negedge clk);
        pdm_line = hi;
        while (pdm_clk) @(negedge clk);
        pdm_line = lo;
        while (!pcm_valid) @(negedge clk);
        chk(req, {28'd0, pcm_bits}, {28'd0, exp});
    endtask

    task automatic load_cfg(input logic [3:0] s, input logic [3:0] l);
        cfg_slot = s;
        cfg_line = l;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic stop_all();
        chan_en = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n;
        logic [3:0] held;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 clk", {31'd0, pdm_clk}, 0);
        chk("R9 valid", {31'd0, pcm_valid}, 0);
        chk("R9 bits", {28'd0, pcm_bits}, 0);

        // R2 clock silent while no channel enabled
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (pdm_clk || pcm_valid) n++;
            @(negedge clk);
        end
        chk("R2 idle activity", n, 0);

        // R3 R4 R6 R9 table walk with reset routing
        for (int i = 0; i < 8; i++)
            period("R3/R4/R6 table", VEC[i][7:4], VEC[i][3:2], VEC[i][1:0],
                   model(VEC[i][7:4], VEC[i][3:2], VEC[i][1:0]));
        period("R9 default route", 4'hF, 2'b01, 2'b10, 4'b1001);

        // R1 phase lengths
        chan_en = 4'hF;
        while (pdm_clk) @(negedge clk);
        while (!pdm_clk) @(negedge clk);
        n = 0;
        while (pdm_clk) begin n++; @(negedge clk); end
        chk("R1 high cycles", n, 8);
        n = 0;
        while (!pdm_clk) begin n++; @(negedge clk); end
        chk("R1 low cycles", n, 8);

        // R5 one strobe per period, bits held between strobes
        n = 0;
        held = pcm_bits;
        begin
            int moved = 0;
            for (int i = 0; i < 64; i++) begin
                if (pcm_valid) begin n++; held = pcm_bits; end
                else if (pcm_bits !== held) moved++;
                @(negedge clk);
            end
            chk("R5 strobes in 64 cycles", n, 4);
            chk("R5 bits moved without strobe", moved, 0);
        end

        // R7 load while capturing is ignored
        load_cfg(4'b0101, 4'b1100);
        period("R7 load while enabled", 4'hF, 2'b01, 2'b10, model(4'hF, 2'b01, 2'b10));

        // R2 stop
        chan_en = '0;
        @(negedge clk);
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (pdm_clk || pcm_valid) n++;
            @(negedge clk);
        end
        chk("R2 stopped activity", n, 0);

        // R8 duplicate pair refused
        load_cfg(4'b0000, 4'b1100);
        period("R8 clash ignored", 4'hF, 2'b01, 2'b10, model(4'hF, 2'b01, 2'b10));
        stop_all();

        // R7 legal load while stopped
        load_cfg(4'b0101, 4'b1100);
        m_slot = 4'b0101;
        m_line = 4'b1100;
        period("R7 new route", 4'hF, 2'b01, 2'b10, 4'b0110);
        period("R7 new route b", 4'hF, 2'b10, 2'b00, model(4'hF, 2'b10, 2'b00));
        stop_all();
        load_cfg(4'b1100, 4'b0101);
        m_slot = 4'b1100;
        m_line = 4'b0101;
        period("R4 swapped wires", 4'hF, 2'b01, 2'b10, model(4'hF, 2'b01, 2'b10));
        period("R3 swapped slots", 4'h3, 2'b10, 2'b01, model(4'h3, 2'b10, 2'b01));
        stop_all();

        // R1 restart: clock high in the first cycle after enabling
        chan_en = 4'h2;
        @(negedge clk);
        chk("R1 restart edge", {31'd0, pdm_clk}, 1);
        stop_all();

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule